// File: doc/BRIEF.md
# Millisecond Periodic Interrupt Timer

This block produces a repeating interrupt whose interval is set in whole milliseconds. A one-cycle strobe arriving once per millisecond drives an internal counter. When the counter has seen as many strobes as the programmed interval, it wraps to zero and latches a detect flag. The interrupt output is that flag, gated by a separate interrupt enable. Counting and interrupt signalling therefore have independent enables. Software can keep the timer running with its interrupt masked, and can poll the flag instead.

Software reaches the block through a small register port. A write strobe, a 2-bit select and a data word update either the control/status word or the interval register. A combinational read path returns one of the control/status word, the interval or the live counter, chosen by a second select. The flag is cleared by writing one to its bit. Intervals of 1 to 1000 ms give rates from 1000 Hz down to 1 Hz. An interval of zero switches the flag source off.

Top module: `ms_periodic_timer`

## Requirements
- R1: After reset the interval, counter, count enable, interrupt enable and flag are all zero, and `irq` is low.
- R2: A write with select 1 loads the low 10 bits of the data into the interval register. A read with select 1 returns that value zero-extended.
- R3: The counter advances by one only in a cycle where `ms_tick` is high and the count enable (control/status bit 15) is set. Otherwise it holds.
- R4: While the count enable is clear, the counter is held at zero at the next clock.
- R5: On the strobe that would bring the counter to the interval value, the counter returns to zero and the flag (bit 13) is set. With the counter enabled and a strobe every cycle, the flag therefore rises every N cycles for an interval of N.
- R6: An interval of zero never sets the flag, and the counter stays at zero.
- R7: A select-0 write with bit 13 set clears the flag. A write with bit 13 clear leaves it unchanged. If an expiry happens in the same cycle as the clear, the flag stays set.
- R8: `irq` is high exactly when the flag is set and the interrupt enable (bit 14) is set. The flag still latches while the interrupt enable is clear.
- R9: A select-1 write forces the counter to zero, and no expiry is reported in that cycle.
- R10: Reads with select 0 return the enables and flag in bits 15:13 and zero elsewhere. Select 2 returns the counter and select 3 returns zero. Writes with select 2 or 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control/status, 1 interval |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source: 0 control/status, 1 interval, 2 counter, 3 zero |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Periodic interrupt level |

## Verification
The counter is first driven with a strobe on every cycle. It is then driven with sparse, irregular strobes, which separates counting of strobes from counting of clocks. Intervals of 1, 3 and 1000 exercise the wrap compare at its smallest, a typical value and the upper limit. An interval of zero checks that the disabled case raises nothing. Writes are placed on purpose in the same cycle as an expiry, both a flag clear and an interval reload, to expose the priority chosen between them. A run with the interrupt enable clear shows that the flag and the output are gated apart.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W   = 16;
  localparam int PERIOD_W = 10;
  localparam int CE_BIT   = 15;
  localparam int AE_BIT   = 14;
  localparam int FL_BIT   = 13;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } pit_sel_e;

  typedef struct packed {
    logic                expire;
    logic [PERIOD_W-1:0] next;
  } pit_step_t;

  // One counting step: advance on a strobe, wrap at the interval.
  function automatic pit_step_t pit_step(input logic [PERIOD_W-1:0] cnt,
                                         input logic [PERIOD_W-1:0] period,
                                         input logic                strobe);
    pit_step_t r;
    logic [PERIOD_W:0] inc;
    inc = {1'b0, cnt} + 1'b1;
    r.expire = 1'b0;
    r.next   = cnt;
    if (strobe && (period != '0)) begin
      if (inc == {1'b0, period}) begin
        r.expire = 1'b1;
        r.next   = '0;
      end else begin
        r.next = inc[PERIOD_W-1:0];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PERIOD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [PW-1:0] period,
  output logic          cnt_en,
  output logic          alm_en,
  output logic          period_wr,
  output logic          flag_clr
);
  logic ctrl_wr;

  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign period_wr = wr_en && (wr_sel == SEL_PERIOD);
  assign flag_clr  = ctrl_wr && wr_data[FL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;
      cnt_en <= 1'b0;
      alm_en <= 1'b0;
    end else begin
      if (period_wr) period <= wr_data[PW-1:0];
      if (ctrl_wr) begin
        cnt_en <= wr_data[CE_BIT];
        alm_en <= wr_data[AE_BIT];
      end
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int PW = PERIOD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          cnt_en,
  input  logic          restart,
  input  logic [PW-1:0] period,
  output logic [PW-1:0] count,
  output logic          expire
);
  pit_step_t step;

  always_comb begin
    step   = pit_step(count, period, ms_tick && cnt_en);
    expire = step.expire && !restart;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (!cnt_en) count <= '0;
    else              count <= step.next;
  end
endmodule

// File: rtl/pit_flag.sv
module pit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  // A new expiry outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/ms_periodic_timer.sv
module ms_periodic_timer
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [PERIOD_W-1:0] period;
  logic [PERIOD_W-1:0] count;
  logic cnt_en, alm_en, period_wr, flag_clr, expire, flag;

  pit_regs #(.DW(DATA_W), .PW(PERIOD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .period(period), .cnt_en(cnt_en),
    .alm_en(alm_en), .period_wr(period_wr), .flag_clr(flag_clr)
  );

  pit_counter #(.PW(PERIOD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cnt_en(cnt_en),
    .restart(period_wr), .period(period), .count(count), .expire(expire)
  );

  pit_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(expire), .clr_i(flag_clr), .flag(flag)
  );

  assign irq = flag & alm_en;

  always_comb begin
    rd_data = '0;
    unique case (pit_sel_e'(rd_sel))
      SEL_CTRL: begin
        rd_data[CE_BIT] = cnt_en;
        rd_data[AE_BIT] = alm_en;
        rd_data[FL_BIT] = flag;
      end
      SEL_PERIOD: rd_data[PERIOD_W-1:0] = period;
      SEL_COUNT:  rd_data[PERIOD_W-1:0] = count;
      SEL_NONE:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pit_checker.sv
module pit_checker
  import pit_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [PERIOD_W-1:0] period,
  input logic [PERIOD_W-1:0] count,
  input logic                cnt_en,
  input logic                alm_en,
  input logic                expire,
  input logic                flag,
  input logic                flag_clr,
  input logic                period_wr,
  input logic                irq
);
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (count == '0));

  p_below_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (count < period));

  p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  p_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |-> (!expire && count == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !expire) |=> !flag);

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (alm_en && flag));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> (count == '0));
endmodule

bind ms_periodic_timer pit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .period(period), .count(count),
  .cnt_en(cnt_en), .alm_en(alm_en), .expire(expire), .flag(flag),
  .flag_clr(flag_clr), .period_wr(period_wr), .irq(irq)
);

// File: tb/tb_ms_periodic_timer.sv
module tb_ms_periodic_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt = 0, m_per = 0, m_ce = 0, m_ae = 0, m_fl = 0;
  int irq_rises = 0;

  always #4 clk = ~clk;

  ms_periodic_timer dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_read(input int sel);
    case (sel)
      0: return (m_ce << 15) | (m_ae << 14) | (m_fl << 13);
      1: return m_per;
      2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int hit;
    bit pw, cw;
    pw = wr_en && wr_sel == 2'd1;
    cw = wr_en && wr_sel == 2'd0;
    hit = 0;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_ce = 0; m_ae = 0; m_fl = 0;
      return;
    end
    if (m_ce && ms_tick && m_per != 0 && !pw && (m_cnt + 1 == m_per)) hit = 1;
    if (pw || !m_ce) m_cnt = 0;
    else if (ms_tick && m_per != 0) m_cnt = hit ? 0 : m_cnt + 1;
    if (hit) m_fl = 1;
    else if (cw && wr_data[13]) m_fl = 0;
    if (cw) begin m_ce = wr_data[15]; m_ae = wr_data[14]; end
    if (pw) m_per = wr_data[9:0];
  endtask

  // one clock: inputs already set; update model at the edge, compare mid-cycle
  task automatic cyc(input bit tk, input bit we, input int ws, input int wd,
                     input int rs);
    bit prev_irq;
    ms_tick = tk; wr_en = we; wr_sel = ws[1:0]; wr_data = wd[15:0];
    rd_sel = rs[1:0];
    prev_irq = irq;
    @(posedge clk);
    model_step();
    @(negedge clk);
    ms_tick = 0; wr_en = 0;
    check({cur_req, " irq"}, irq, (m_fl && m_ae) ? 1 : 0);
    check({cur_req, " rd_data"}, rd_data, model_read(rs));
    if (irq && !prev_irq) irq_rises++;
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(tk, 0, 0, 0, i % 3);
  endtask

  task automatic wr(input int ws, input int wd);
    cyc(0, 1, ws, wd, ws);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk); model_step();
    @(negedge clk); model_step();
    rst_n = 1;
    cur_req = "R1";
    for (int s = 0; s < 4; s++) cyc(0, 0, 0, 0, s);

    // R2: interval register load, upper bits dropped
    cur_req = "R2";
    wr(1, 16'hFC03);
    check("R2 period readback", rd_data, 3);

    // R5, R8: every-cycle strobes, interval 3, both enables
    cur_req = "R5";
    wr(0, 16'hC000);
    irq_rises = 0;
    for (int i = 0; i < 9; i++) begin
      cyc(1, 0, 0, 0, 2);
      if (i == 2) check("R5 flag after 3 strobes", irq, 1);
      if (i == 1) check("R5 no flag after 2 strobes", irq, 0);
    end
    // R7: write with bit 13 clear keeps flag; write with bit 13 set clears
    cur_req = "R7";
    wr(0, 16'hC000);
    check("R7 zero write keeps flag", rd_data[13], 1);
    wr(0, 16'hE000);
    check("R7 one write clears flag", rd_data[13], 0);

    // R3: sparse strobes, count only strobes
    cur_req = "R3";
    for (int i = 0; i < 7; i++) cyc(i % 3 == 0, 0, 0, 0, 2);
    check("R3 count after 3 sparse strobes", rd_data, 0);
    idle(2, 0);

    // R7: expiry in same cycle as clear keeps flag
    cur_req = "R7";
    wr(1, 2);
    cyc(1, 0, 0, 0, 2);
    cyc(1, 1, 0, 16'hE000, 0);
    check("R7 expiry outranks clear", rd_data[13], 1);

    // R8: interrupt enable off, flag still latches
    cur_req = "R8";
    wr(0, 16'hA000);
    check("R8 flag cleared", rd_data[13], 0);
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    check("R8 flag latched while masked", rd_data[13], 1);
    check("R8 irq masked", irq, 0);
    wr(0, 16'h4000);
    check("R8 irq after unmask", irq, 1);

    // R4: count enable clear holds counter at zero
    cur_req = "R4";
    wr(0, 16'hE000);
    wr(1, 5);
    cyc(1, 0, 0, 0, 2); cyc(1, 0, 0, 0, 2);
    check("R4 counting before disable", rd_data, 2);
    wr(0, 16'h4000);
    cyc(1, 0, 0, 0, 2);
    check("R4 held at zero", rd_data, 0);
    idle(3, 1);

    // R9: interval write restarts, and cancels a coincident expiry
    cur_req = "R9";
    wr(0, 16'hC000);
    wr(1, 4);
    idle(3, 1);
    cyc(1, 1, 1, 4, 2);
    check("R9 restart on write", rd_data, 0);
    check("R9 no expiry on write cycle", irq, 0);
    idle(5, 1);

    // R6: zero interval never flags
    cur_req = "R6";
    wr(0, 16'hE000);
    wr(1, 0);
    idle(12, 1);
    check("R6 no flag with zero interval", irq, 0);

    // R10: writes to selects 2 and 3 ignored; reads of 3 are zero
    cur_req = "R10";
    wr(1, 1);
    wr(2, 16'hFFFF);
    wr(3, 16'hFFFF);
    cyc(0, 0, 0, 0, 1);
    check("R10 period untouched", rd_data, 1);
    cyc(0, 0, 0, 0, 3);
    check("R10 select 3 reads zero", rd_data, 0);

    // R5: interval 1 flags on every strobe; interval 1000 boundary
    cur_req = "R5";
    idle(4, 1);
    wr(0, 16'hE000);
    wr(1, 1000);
    wr(0, 16'hE000);
    irq_rises = 0;
    for (int i = 0; i < 2001; i++) cyc(1, 0, 0, 0, i % 3);
    check("R5 one expiry per 1000 strobes", irq_rises, 1);
    check("R5 flag held", irq, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule